// File: doc/BRIEF.md
# UART Receive Buffer and Interrupt Generator

This block is the receive-side store of a 16550-style serial port. The receiver shift stage in front of it hands over one byte per `rx_valid` pulse, together with a parity-error flag and a framing-error flag for that byte. The byte and its flags go into a 16-entry first-in first-out buffer. The host drains the buffer one entry at a time with a read strobe. It watches a small line-status vector that shows whether data is ready and which errors have been seen since the last status read.

One interrupt line combines three causes. In order of priority these are a receive error, the fill level reaching a programmable trigger point, and a character timeout. The timeout fires when bytes sit in the buffer with no push or pop for four character times, counted in bit-time strobes from the baud generator. This lets software collect a tail of bytes that never reaches the trigger point. An identification output names the highest pending cause.

Top module: `uart_rx_buffer`

## Requirements
- R1: The buffer holds up to 16 entries and returns them in arrival order. A one-cycle `rbr_rd` pulse removes the oldest entry, and its byte and error flags appear on `rd_data`/`rd_perr`/`rd_ferr` from the following cycle. `rbr_rd` on an empty buffer removes nothing and leaves those outputs unchanged.
- R2: `line_status[0]` (data ready) is 1 exactly while the buffer holds at least one entry.
- R3: A byte that arrives while 16 entries are held is dropped, even if `rbr_rd` is pulsed in the same cycle. The drop sets `line_status[1]` (overrun).
- R4: An arriving byte with its parity flag set sets `line_status[2]`, and one with its framing flag set sets `line_status[3]`. The byte is still stored and keeps its own flags.
- R5: A one-cycle `lsr_rd` pulse clears `line_status[3:1]`. If an error arrives in the same cycle, the new error flag stays set.
- R6: `trig_sel` picks the trigger level: 0 gives 1 entry, 1 gives 4, 2 gives 8 and 3 gives 14. The trigger cause is pending while the fill is at or above that level.
- R7: The timeout cause becomes pending when the buffer is non-empty and 40 bit strobes (4 characters of 10 bits) have passed with no accepted push and no pop. Every accepted push or pop restarts the count and removes a pending timeout.
- R8: `irq_id` reports 0 for none, 1 for a receive error (any of `line_status[3:1]`), 2 for trigger and 3 for timeout, choosing the lowest nonzero code that is pending. `irq` is 1 exactly when `irq_id` is nonzero. Both are registered and follow the pending causes one cycle later.
- R9: A `fifo_clear` pulse empties the buffer and cancels the timeout. It takes precedence over a push or pop in the same cycle and leaves `line_status[3:1]` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is offered |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error on this byte |
| rx_ferr | input | 1 | Framing error on this byte |
| bit_tick | input | 1 | One pulse per serial bit time |
| trig_sel | input | 2 | Trigger level select (1/4/8/14) |
| fifo_clear | input | 1 | Empty the buffer and cancel the timeout |
| rbr_rd | input | 1 | Pop the oldest entry |
| lsr_rd | input | 1 | Line status read; clears error bits |
| rd_data | output | 8 | Last popped byte |
| rd_perr | output | 1 | Parity flag of the last popped byte |
| rd_ferr | output | 1 | Framing flag of the last popped byte |
| line_status | output | 4 | {framing, parity, overrun, data ready} |
| irq | output | 1 | Combined interrupt |
| irq_id | output | 2 | Highest pending cause |

## Verification
A corrupted pointer or fill count shows up at the next pop as a byte out of order, and at once on the data-ready bit. A wrong fill also moves the trigger cause on `irq_id` one cycle later. A mis-sized or stuck timeout counter is caught by sampling `irq_id` one strobe before and one strobe after the 40-strobe boundary. Flag and priority faults appear as a wrong `irq_id` in the cycle after the error arrives or the status read happens.

// File: rtl/urb_pkg.sv
package urb_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_LINE = 2'd1,
    CAUSE_TRIG = 2'd2,
    CAUSE_TOUT = 2'd3
  } urb_cause_e;

  // Trigger fill level for each select code.
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/urb_fifo.sv
module urb_fifo #(
  parameter int DW    = 10,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          empty;

  assign full    = (fill == CW'(DEPTH));
  assign empty   = (fill == '0);
  assign push_ok = push && !full && !clear;
  assign pop_ok  = pop && !empty && !clear;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage: write port and registered read port, no reset.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (pop_ok) rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));

  assert_empty_pop_R1: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> $stable(rdata));

endmodule

// File: rtl/urb_timer.sv
module urb_timer #(
  parameter int CHAR_BITS = 10,
  parameter int TO_CHARS  = 4,
  localparam int LIMIT    = CHAR_BITS * TO_CHARS,
  localparam int TW       = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic activity,
  input  logic empty,
  input  logic bit_tick,
  output logic expired
);

  logic [TW-1:0] ticks;

  always_ff @(posedge clk) begin
    if (rst || clear || activity || empty) begin
      ticks   <= '0;
      expired <= 1'b0;
    end else if (bit_tick && !expired) begin
      if (ticks == TW'(LIMIT - 1)) begin
        ticks   <= '0;
        expired <= 1'b1;
      end else begin
        ticks <= ticks + 1'b1;
      end
    end
  end

  assert_tout_needs_data_R7: assert property (@(posedge clk) disable iff (rst)
    expired |-> !empty);

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import urb_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CHAR_BITS = 10,
  parameter int TO_CHARS  = 4,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       bit_tick,
  input  logic [1:0] trig_sel,
  input  logic       fifo_clear,
  input  logic       rbr_rd,
  input  logic       lsr_rd,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic [3:0] line_status,
  output logic       irq,
  output logic [1:0] irq_id
);

  logic [CW-1:0] fill;
  logic          full, push_ok, pop_ok, tout;
  logic [9:0]    rd_word;
  logic          oe_q, pe_q, fe_q;
  urb_cause_e    cause, id_q;

  urb_fifo #(.DW(10), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .clear(fifo_clear),
    .push(rx_valid), .wdata({rx_ferr, rx_perr, rx_byte}),
    .pop(rbr_rd), .rdata(rd_word), .fill(fill), .full(full),
    .push_ok(push_ok), .pop_ok(pop_ok)
  );

  urb_timer #(.CHAR_BITS(CHAR_BITS), .TO_CHARS(TO_CHARS)) timer_i (
    .clk(clk), .rst(rst), .clear(fifo_clear),
    .activity(push_ok || pop_ok), .empty(fill == '0),
    .bit_tick(bit_tick), .expired(tout)
  );

  assign rd_data = rd_word[7:0];
  assign rd_perr = rd_word[8];
  assign rd_ferr = rd_word[9];

  // Sticky error flags: a new error in the same cycle beats the clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= 1'b0;
      pe_q <= 1'b0;
      fe_q <= 1'b0;
    end else begin
      oe_q <= (oe_q && !lsr_rd) || (rx_valid && full);
      pe_q <= (pe_q && !lsr_rd) || (rx_valid && rx_perr);
      fe_q <= (fe_q && !lsr_rd) || (rx_valid && rx_ferr);
    end
  end

  assign line_status = {fe_q, pe_q, oe_q, (fill != '0)};

  always_comb begin
    if (oe_q || pe_q || fe_q)                  cause = CAUSE_LINE;
    else if (fill >= CW'(trig_level(trig_sel))) cause = CAUSE_TRIG;
    else if (tout)                             cause = CAUSE_TOUT;
    else                                       cause = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q <= CAUSE_NONE;
      irq  <= 1'b0;
    end else begin
      id_q <= cause;
      irq  <= (cause != CAUSE_NONE);
    end
  end

  assign irq_id = id_q;

  assert_overrun_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && full && !fifo_clear) |=> (line_status[1] && fill == CW'(DEPTH) - CW'($past(rbr_rd))));

  assert_line_first_R8: assert property (@(posedge clk) disable iff (rst)
    (oe_q || pe_q || fe_q) |=> (irq_id == 2'd1 && irq));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    fifo_clear |=> (fill == '0 && !tout));

  assert_err_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_perr) |=> line_status[2]);

endmodule

// File: tb/uart_rx_buffer_tb_top.sv
module uart_rx_buffer_tb_top;

  localparam int DEPTH = 16;
  localparam int LIMIT = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 0, rx_perr = 0, rx_ferr = 0, bit_tick = 0;
  logic [7:0] rx_byte = 0;
  logic [1:0] trig_sel = 0;
  logic       fifo_clear = 0, rbr_rd = 0, lsr_rd = 0;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, irq;
  logic [3:0] line_status;
  logic [1:0] irq_id;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Bench model
  logic [9:0] q[$];
  bit m_oe, m_pe, m_fe, m_to;

  always #10 clk = ~clk;

  uart_rx_buffer dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .bit_tick(bit_tick),
    .trig_sel(trig_sel), .fifo_clear(fifo_clear), .rbr_rd(rbr_rd),
    .lsr_rd(lsr_rd), .rd_data(rd_data), .rd_perr(rd_perr),
    .rd_ferr(rd_ferr), .line_status(line_status), .irq(irq), .irq_id(irq_id)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  function automatic int lvl(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int exp_id();
    if (m_oe || m_pe || m_fe) return 1;
    if (q.size() >= lvl(trig_sel)) return 2;
    if (m_to) return 3;
    return 0;
  endfunction

  function automatic int exp_ls();
    return {m_fe, m_pe, m_oe, q.size() != 0};
  endfunction

  // One cycle with optional push, pop and status read; updates the model.
  task automatic op(input bit p, input logic [7:0] b, input bit pe, input bit fe,
                    input bit r, input bit l);
    logic [9:0] popped;
    bit was_full, did_pop;
    was_full = (q.size() == DEPTH);
    did_pop = 0;
    rx_valid = p; rx_byte = b; rx_perr = pe; rx_ferr = fe; rbr_rd = r; lsr_rd = l;
    cyc();
    rx_valid = 0; rx_perr = 0; rx_ferr = 0; rbr_rd = 0; lsr_rd = 0;
    if (l) begin m_oe = 0; m_pe = 0; m_fe = 0; end
    if (r && q.size() > 0) begin popped = q.pop_front(); did_pop = 1; end
    if (p) begin
      if (was_full) m_oe = 1; else q.push_back({fe, pe, b});
      m_pe |= pe; m_fe |= fe;
    end
    if (did_pop || (p && !was_full)) m_to = 0;
    if (did_pop) chk("R1 pop data", {rd_ferr, rd_perr, rd_data}, popped);
  endtask

  task automatic check_state(input string req);
    chk({req, " line_status (R2)"}, line_status, exp_ls());
    cyc();
    chk({req, " irq_id (R8)"}, irq_id, exp_id());
    chk({req, " irq (R8)"}, irq, exp_id() != 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; cyc(); bit_tick = 0;
    end
  endtask

  task automatic drain();
    while (q.size() > 0) op(0, 0, 0, 0, 1, 0);
    op(0, 0, 0, 0, 0, 1);
    m_to = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [7:0] hold;
    seed = $urandom(32'h5eed);
    repeat (3) cyc();
    rst = 0;
    cyc();
    chk("R2 reset line_status", line_status, 0);
    chk("R8 reset irq_id", irq_id, 0);
    chk("R8 reset irq", irq, 0);

    // R1: pop on empty leaves rd_data unchanged
    op(1, 8'hA5, 0, 0, 0, 0);
    op(0, 0, 0, 0, 1, 0);
    hold = rd_data;
    rbr_rd = 1; cyc(); rbr_rd = 0;
    chk("R1 empty pop ignored", rd_data, hold);
    check_state("R1 empty");

    // R6: trigger levels at threshold edge
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int k = 0; k < lvl(2'(s)) - 1; k++) op(1, 8'(k + 16 * s), 0, 0, 0, 0);
      check_state("R6 below level");
      op(1, 8'hEE, 0, 0, 0, 0);
      check_state("R6 at level");
      drain();
    end

    // R3: fill to 16 then push with simultaneous pop is dropped
    trig_sel = 2'd3;
    for (int k = 0; k < DEPTH; k++) op(1, 8'(k + 100), 0, 0, 0, 0);
    op(1, 8'h77, 0, 0, 1, 0);
    check_state("R3 overrun");
    chk("R3 fill after drop", q.size(), DEPTH - 1);
    // R5: a new error in the same cycle as status read stays set
    op(0, 0, 0, 0, 1, 1);
    check_state("R5 cleared");
    op(0, 0, 0, 0, 1, 0);
    drain();
    q.push_back(10'h0); // placeholder to enable next op; removed below
    void'(q.pop_back());
    op(1, 8'h31, 1, 0, 0, 1);
    check_state("R5 new error wins");
    op(1, 8'h32, 0, 1, 0, 0);
    check_state("R4 framing stored");
    drain();

    // R9: clear beats push, keeps error flags
    op(1, 8'h41, 0, 0, 0, 0);
    op(1, 8'h42, 1, 0, 0, 0);
    fifo_clear = 1; rx_valid = 1; rx_byte = 8'h43; cyc();
    fifo_clear = 0; rx_valid = 0;
    q.delete(); m_pe = 1;
    check_state("R9 clear");
    op(0, 0, 0, 0, 0, 1);
    check_state("R9 after status read");

    // R7 and R6: trigger 8 with 34 bytes -> 4 trigger events, 2 left for timeout
    trig_sel = 2'd2;
    begin
      int trig_events = 0;
      for (int k = 0; k < 34; k++) begin
        op(1, 8'(k), 0, 0, 0, 0);
        cyc();
        if (irq_id == 2'd2) begin
          trig_events++;
          for (int j = 0; j < 8; j++) op(0, 0, 0, 0, 1, 0);
        end
      end
      chk("R6 trigger events for 34 bytes", trig_events, 4);
    end
    chk("R7 leftover count", q.size(), 2);
    ticks(LIMIT - 1); cyc();
    chk("R7 no timeout one strobe early", irq_id, 0);
    ticks(1); m_to = 1;
    check_state("R7 timeout");
    op(0, 0, 0, 0, 1, 0);
    check_state("R7 pop cancels timeout");
    ticks(LIMIT - 5);
    op(1, 8'h99, 0, 0, 0, 0);
    ticks(LIMIT - 1); cyc();
    chk("R7 push restarts count", irq_id, 0);
    ticks(1); m_to = 1;
    check_state("R7 timeout after restart");
    // R8: error outranks timeout
    op(1, 8'h55, 0, 1, 0, 0);
    check_state("R8 priority line over others");
    fifo_clear = 1; cyc(); fifo_clear = 0;
    q.delete(); m_to = 0;
    op(0, 0, 0, 0, 0, 1);
    check_state("R9 clear cancels timeout");

    // Random traffic, no bit strobes
    for (int it = 0; it < 600; it++) begin
      int kind;
      if (it % 50 == 0) trig_sel = 2'($urandom % 4);
      kind = $urandom % 8;
      case (kind)
        0, 1, 2, 3: op(1, 8'($urandom), ($urandom % 10) == 0, ($urandom % 10) == 0, 0, 0);
        4, 5:       op(0, 0, 0, 0, 1, 0);
        6:          op(0, 0, 0, 0, 0, 1);
        default:    op(1, 8'($urandom), 0, 0, 1, 0);
      endcase
      check_state("R1 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule